// File: doc/BRIEF.md
# SDRAM power-up and access sequencer

This block sits between a simple host request port and a four-bank single-data-rate SDRAM. Once reset is released it runs the power-up sequence the memory needs. First comes a long wait of NOP commands, sized from a clock-frequency parameter. Then it issues one precharge to every bank, two auto-refresh commands, and finally the load of the mode register. During all of this the host sees `ready` low.

After setup, the host can hand over one burst request at a time. A request is a read/write flag plus a flat 22-bit word address. The block splits that address into bank, row and column. It then issues an activate, then the read or write, then a single-bank precharge, and places the fields on the bank and address pins. NOP cycles pad each gap so that the timing parameters hold. For reads it raises a data-valid strobe for the cycles in which the memory returns the burst. Burst length and CAS latency are both taken from the programmed mode-register parameter.

Top module: `sdr_seq_ctrl`

## Requirements
- R1: While reset is held, chip select is high (command inhibit) and `ready` is low. After release, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (0111) for exactly CLK_MHZ*WAIT_US cycles (20000 by default), and chip select never goes high again.
- R2: The first command after the wait is PRECHARGE (0010) with address bit 10 high, so that it applies to all banks.
- R3: Two AUTO REFRESH commands (0001) follow. The first comes T_RP cycles after the precharge and the second T_RC cycles after the first, with no other command in between.
- R4: LOAD MODE (0000) comes T_RC cycles after the second refresh. It carries MODE_REG on A11:A0 and 0 on BA1:BA0.
- R5: `ready` stays low until T_MRD-1 cycles after the LOAD MODE cycle and is high from that cycle on, so no ACTIVE, READ or WRITE can come before setup ends.
- R6: A request is taken at the clock edge where `req_valid` and `ready` are both high. In the next cycle, ACTIVE (0011) is driven with BA = req_addr[21:20] and A = req_addr[19:8], the row.
- R7: T_RCD cycles after ACTIVE, READ (0101) or WRITE (0100) is driven with the same bank. The column req_addr[7:0] goes on A7:A0 and A11:A8 are 0, so A10 is low and there is no auto-precharge.
- R8: PRECHARGE (0010) of the same bank follows with A10 low. It comes BL cycles after a WRITE or CL+BL cycles after a READ. `ready` returns T_RP-1 cycles after that precharge.
- R9: BL = 2^MODE_REG[2:0] and CL = MODE_REG[6:4] (4 and 2 by default). After a READ, `rd_valid` is high for BL consecutive cycles starting CL cycles after the READ cycle. It stays low throughout a write access.
- R10: A request presented while `ready` is low is ignored: no extra command is issued for it, and the access in progress keeps its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every output is registered on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 22 | Word address: [21:20] bank, [19:8] row, [7:0] column |
| ready | output | 1 | Block can take a request this cycle |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank select |
| sd_addr | output | 12 | SDRAM address pins |
| rd_valid | output | 1 | Read data is on the bus this cycle |

## Verification
Several situations are hard to bring about from the ports. One is a request that arrives while an access is still in progress. Another is the cycle where `ready` comes back. To reach them, the bench keeps `req_valid` high with a second, different address for the whole of an access. It drops the request in the very cycle `ready` returns, before the next edge can take it. The bench then checks that only the three commands of the first address were logged. Power-up spacing and read-strobe timing are checked against cycle stamps of every non-NOP command, and the address corners tested are all-zero and all-one addresses.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
    // Fixed address split of the memory: 4 banks, 4096 rows, 256 columns
    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;

    // Command pins packed as {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_INH   = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_READ  = 4'b0101;
    localparam logic [3:0] CMD_WRITE = 4'b0100;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;
    localparam logic [3:0] CMD_LMR   = 4'b0000;

    // Each state names the command issued once the gap counter reaches zero
    typedef enum logic [2:0] {
        ST_PREA,
        ST_REF1,
        ST_REF2,
        ST_MRS,
        ST_IDLE,
        ST_RW,
        ST_PRE
    } seq_st_e;
endpackage

// File: rtl/sdr_gap_cnt.sv
module sdr_gap_cnt #(
    parameter int CW      = 16,
    parameter int RST_VAL = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3
    gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);
endmodule

// File: rtl/sdr_rd_strobe.sv
module sdr_rd_strobe #(
    parameter int CL = 2,
    parameter int BL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic rd_valid
);
    localparam int BW = $clog2(BL + 1);

    logic [CL-1:0] sr_d, sr_q;
    logic [BW-1:0] bcnt_d, bcnt_q;
    logic          tap;

    generate
        if (CL == 1) begin : g_cl_one
            always_comb sr_d = rd_issue;
        end else begin : g_cl_multi
            always_comb sr_d = {sr_q[CL-2:0], rd_issue};
        end
    endgenerate

    assign tap = sr_q[CL-1];

    always_comb begin
        if (tap) begin
            bcnt_d = BW'(BL - 1);
        end else if (bcnt_q != '0) begin
            bcnt_d = bcnt_q - 1'b1;
        end else begin
            bcnt_d = bcnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else begin
            sr_q   <= sr_d;
            bcnt_q <= bcnt_d;
        end
    end

    assign rd_valid = tap | (bcnt_q != '0);

    // R9
    burst_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap |-> (bcnt_q == '0));
endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
    import sdr_seq_pkg::*;
#(
    parameter int          CLK_MHZ  = 100,
    parameter int          WAIT_US  = 200,
    parameter int          T_RP     = 2,
    parameter int          T_RC     = 6,
    parameter int          T_MRD    = 2,
    parameter int          T_RCD    = 2,
    parameter logic [11:0] MODE_REG = 12'h022
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [21:0] req_addr,
    output logic        ready,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic [1:0]  sd_ba,
    output logic [11:0] sd_addr,
    output logic        rd_valid
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int BL       = 1 << MODE_REG[2:0];
    localparam int CL       = int'(MODE_REG[6:4]);
    localparam int GAP_MAX  = (WAIT_CYC > 64) ? WAIT_CYC : 64;
    localparam int CW       = $clog2(GAP_MAX + 1);

    typedef struct packed {
        seq_st_e            st;
        logic [3:0]         cmd;
        logic [BANK_W-1:0]  ba;
        logic [ROW_W-1:0]   a;
        logic               wr;
        logic [COL_W-1:0]   col;
        logic [BANK_W-1:0]  bank;
    } seq_t;

    seq_t          d, q;
    logic          gap_zero;
    logic          gap_load;
    logic [CW-1:0] gap_val;

    sdr_gap_cnt #(
        .CW      (CW),
        .RST_VAL (WAIT_CYC)
    ) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    always_comb begin
        d        = q;
        d.cmd    = CMD_NOP;
        gap_load = 1'b0;
        gap_val  = '0;
        if (gap_zero) begin
            case (q.st)
                ST_PREA: begin
                    d.cmd    = CMD_PRE;
                    d.ba     = '0;
                    d.a      = 12'h400;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_RP - 1);
                    d.st     = ST_REF1;
                end
                ST_REF1: begin
                    d.cmd    = CMD_REF;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_RC - 1);
                    d.st     = ST_REF2;
                end
                ST_REF2: begin
                    d.cmd    = CMD_REF;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_RC - 1);
                    d.st     = ST_MRS;
                end
                ST_MRS: begin
                    d.cmd    = CMD_LMR;
                    d.ba     = '0;
                    d.a      = MODE_REG;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_MRD - 1);
                    d.st     = ST_IDLE;
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        d.cmd    = CMD_ACT;
                        d.ba     = req_addr[21:20];
                        d.a      = req_addr[19:8];
                        d.bank   = req_addr[21:20];
                        d.col    = req_addr[7:0];
                        d.wr     = req_write;
                        gap_load = 1'b1;
                        gap_val  = CW'(T_RCD - 1);
                        d.st     = ST_RW;
                    end
                end
                ST_RW: begin
                    d.cmd    = q.wr ? CMD_WRITE : CMD_READ;
                    d.ba     = q.bank;
                    d.a      = {4'b0000, q.col};
                    gap_load = 1'b1;
                    gap_val  = q.wr ? CW'(BL - 1) : CW'(CL + BL - 1);
                    d.st     = ST_PRE;
                end
                ST_PRE: begin
                    d.cmd    = CMD_PRE;
                    d.ba     = q.bank;
                    d.a      = '0;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_RP - 1);
                    d.st     = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_PREA;
            q.cmd  <= CMD_INH;
            q.ba   <= '0;
            q.a    <= '0;
            q.wr   <= 1'b0;
            q.col  <= '0;
            q.bank <= '0;
        end else begin
            q <= d;
        end
    end

    sdr_rd_strobe #(
        .CL (CL),
        .BL (BL)
    ) rds_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (q.cmd == CMD_READ),
        .rd_valid (rd_valid)
    );

    assign ready    = (q.st == ST_IDLE) && gap_zero;
    assign sd_cs_n  = q.cmd[3];
    assign sd_ras_n = q.cmd[2];
    assign sd_cas_n = q.cmd[1];
    assign sd_we_n  = q.cmd[0];
    assign sd_ba    = q.ba;
    assign sd_addr  = q.a;

    // R1
    cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !sd_cs_n);

    // R3
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cmd[3] && q.cmd != CMD_NOP) |-> $past(gap_zero));

    // R6
    act_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_ACT) |-> $past(ready && req_valid));

    // R7
    rw_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_READ || q.cmd == CMD_WRITE) |-> $stable(sd_ba));
endmodule

// File: tb/sdr_seq_ctrl_tb_top.sv
module sdr_seq_ctrl_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          CLK_MHZ    = 100;
    localparam int          WAIT_US    = 200;
    localparam int          WAIT_CYC   = CLK_MHZ * WAIT_US;
    localparam int          T_RP       = 2;
    localparam int          T_RC       = 6;
    localparam int          T_MRD      = 2;
    localparam int          T_RCD      = 2;
    localparam logic [11:0] MODE_REG   = 12'h022;
    localparam int          BL         = 4;
    localparam int          CL         = 2;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic        ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_valid;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [3:0]  lcmd [64];
    logic [1:0]  lba  [64];
    logic [11:0] la   [64];
    int          lcyc [64];
    int nlog = 0, pre_nop = 0, inh_seen = 0, rdy_first = -1;
    int rv_first = -1, rv_last = -1, rv_cnt = 0;

    sdr_seq_ctrl #(
        .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_MRD(T_MRD), .T_RCD(T_RCD), .MODE_REG(MODE_REG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .ready(ready), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        if (rst_n) cyc++;
    end

    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (c[3]) inh_seen++;
            else if (c == C_NOP) begin
                if (nlog == 0) pre_nop++;
            end else if (nlog < 64) begin
                lcmd[nlog] = c; lba[nlog] = sd_ba; la[nlog] = sd_addr;
                lcyc[nlog] = cyc; nlog++;
            end
            if (ready && rdy_first < 0) rdy_first = cyc;
            if (rd_valid) begin
                if (rv_cnt == 0) rv_first = cyc;
                rv_last = cyc;
                rv_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sd_cs_n == 1'b1, "R1 reset inhibit", int'(sd_cs_n), 1);
        check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        while (!ready) @(negedge clk);
        #1;
        check(pre_nop == WAIT_CYC, "R1 nop wait", pre_nop, WAIT_CYC);
        check(nlog == 4, "R3 setup command count", nlog, 4);
        check(lcmd[0] == C_PRE, "R2 precharge cmd", int'(lcmd[0]), int'(C_PRE));
        check(la[0][10] == 1'b1, "R2 precharge all A10", int'(la[0][10]), 1);
        check(lcmd[1] == C_REF && lcmd[2] == C_REF, "R3 two refreshes",
              int'(lcmd[2]), int'(C_REF));
        check(lcyc[1] - lcyc[0] == T_RP, "R3 tRP spacing", lcyc[1] - lcyc[0], T_RP);
        check(lcyc[2] - lcyc[1] == T_RC, "R3 tRC spacing", lcyc[2] - lcyc[1], T_RC);
        check(lcmd[3] == C_LMR, "R4 load mode cmd", int'(lcmd[3]), int'(C_LMR));
        check(la[3] == MODE_REG, "R4 mode value", int'(la[3]), int'(MODE_REG));
        check(lba[3] == 2'b00, "R4 mode bank", int'(lba[3]), 0);
        check(lcyc[3] - lcyc[2] == T_RC, "R4 spacing", lcyc[3] - lcyc[2], T_RC);
        check(rdy_first == lcyc[3] + T_MRD - 1, "R5 ready rise", rdy_first,
              lcyc[3] + T_MRD - 1);
        check(inh_seen == 0, "R1 no inhibit after reset", inh_seen, 0);
    endtask

    task automatic t_access(input bit wr, input logic [21:0] addr, input bit hold,
                            input logic [21:0] other);
        int s, acc, back, e;
        s = nlog;
        rv_cnt = 0; rv_first = -1; rv_last = -1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        while (!ready) @(negedge clk);
        acc = cyc;
        @(negedge clk);
        if (hold) begin
            req_addr = other; req_write = ~wr;
            while (!ready) @(negedge clk);
            req_valid = 1'b0;
        end else begin
            req_valid = 1'b0;
            while (!ready) @(negedge clk);
        end
        back = cyc;
        repeat (4) @(negedge clk);
        #1;
        check(nlog == s + 3, hold ? "R10 busy request ignored" : "R8 access command count",
              nlog - s, 3);
        if (nlog < s + 3) return;
        check(lcmd[s] == C_ACT, "R6 active cmd", int'(lcmd[s]), int'(C_ACT));
        check(lcyc[s] == acc + 1, "R6 active cycle", lcyc[s], acc + 1);
        check(lba[s] == addr[21:20], "R6 active bank", int'(lba[s]), int'(addr[21:20]));
        check(la[s] == addr[19:8], "R6 active row", int'(la[s]), int'(addr[19:8]));
        check(lcmd[s+1] == (wr ? C_WR : C_RD), "R7 rw cmd", int'(lcmd[s+1]),
              int'(wr ? C_WR : C_RD));
        check(lcyc[s+1] - lcyc[s] == T_RCD, "R7 tRCD", lcyc[s+1] - lcyc[s], T_RCD);
        check(lba[s+1] == addr[21:20], "R7 rw bank", int'(lba[s+1]), int'(addr[21:20]));
        check(la[s+1] == {4'b0000, addr[7:0]}, "R7 rw column", int'(la[s+1]),
              int'({4'b0000, addr[7:0]}));
        e = wr ? BL : CL + BL;
        check(lcmd[s+2] == C_PRE, "R8 precharge cmd", int'(lcmd[s+2]), int'(C_PRE));
        check(lcyc[s+2] - lcyc[s+1] == e, "R8 precharge spacing",
              lcyc[s+2] - lcyc[s+1], e);
        check(lba[s+2] == addr[21:20] && la[s+2][10] == 1'b0, "R8 precharge bank/A10",
              int'({lba[s+2], la[s+2][10]}), int'({addr[21:20], 1'b0}));
        check(back == lcyc[s+2] + T_RP - 1, "R8 ready return", back,
              lcyc[s+2] + T_RP - 1);
        if (wr) begin
            check(rv_cnt == 0, "R9 no strobe on write", rv_cnt, 0);
        end else begin
            check(rv_first == lcyc[s+1] + CL, "R9 strobe start", rv_first,
                  lcyc[s+1] + CL);
            check(rv_cnt == BL, "R9 strobe length", rv_cnt, BL);
            check(rv_last == lcyc[s+1] + CL + BL - 1, "R9 strobe contiguous",
                  rv_last, lcyc[s+1] + CL + BL - 1);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup();
        t_access(1'b1, {2'd2, 12'hABC, 8'h5D}, 1'b0, '0);
        t_access(1'b0, 22'h3FFFFF, 1'b0, '0);
        t_access(1'b0, 22'h000000, 1'b0, '0);
        t_access(1'b1, 22'h155AA5, 1'b1, 22'h2AA55A);
        t_access(1'b0, {2'd1, 12'h800, 8'hFF}, 1'b1, 22'h3C0F0F);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule